// File: doc/BRIEF.md
# Floating-Point Compare Exception Flag Unit

This unit takes two IEEE-754 single-precision operands and reports which IEEE exception flags a greater-or-equal comparison of them would raise. It does not return the outcome of the comparison. It returns a 32-bit integer flag vector that a pipeline writes into a destination register. No global status register is read or changed. The flags appear only on the output.

Each operand is classified on its own. A NaN, whether quiet or signaling, raises the invalid flag. A denormal is treated as zero for the comparison, and the flush is reported in a dedicated input-flush flag. A request is a pulse on `in_valid`. One cycle later the flag vector is registered and a write-enable is produced. The guard bit gates that write. When the guard is clear, or no request is present, the write-enable stays low and the output keeps its previous value.

Top module: `fcmp_geflags_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `flags_out` equal to 0 and `wr_en` equal to 0.
- R2: Only bit 4 (invalid, 0x10) and bit 5 (input flushed to zero, 0x20) of `flags_out` can ever be 1. Bits 0 to 3 (divide-by-zero, inexact, underflow, overflow), bit 6 (output flushed to zero) and bits 31 to 7 are always 0.
- R3: An operand with exponent field all ones and a nonzero mantissa is a NaN, whether quiet (mantissa bit 22 set) or signaling. If either operand is a NaN, bit 4 (0x10) is set in the written vector.
- R4: An operand with exponent field 0 and a nonzero mantissa is a denormal. If either operand is a denormal, bit 5 (0x20) is set. A zero of either sign is not a denormal and sets no flag.
- R5: Any pair drawn only from normals, signed zeros and the two infinities, such as +INF against -INF or +INF against itself, writes 0x00000000.
- R6: A NaN in one operand together with a denormal in either operand writes 0x30.
- R7: When `in_valid` and `wr_guard` are both 1 at a clock edge, `wr_en` is 1 in the following cycle and `flags_out` holds the vector for the operands sampled at that edge. The latency is one cycle.
- R8: When `wr_guard` is 0 at a clock edge, `wr_en` is 0 in the following cycle and `flags_out` keeps its previous value, whatever the operands are.
- R9: When `in_valid` is 0 at a clock edge, `wr_en` is 0 in the following cycle and `flags_out` keeps its previous value, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| opnd_a | input | 32 | Left operand of the >= compare (single precision) |
| opnd_b | input | 32 | Right operand of the >= compare (single precision) |
| wr_guard | input | 1 | Guard bit; 1 allows the destination write |
| flags_out | output | 32 | Registered exception-flag vector |
| wr_en | output | 1 | Destination write-enable, one cycle after an accepted request |

## Verification
The bench covers several operand classes: quiet and signaling NaNs, and a signaling NaN whose only nonzero mantissa bit is the lowest one. It also covers smallest and largest denormals, both signed zeros, both infinities, and a NaN paired with a denormal. A design that tested only the quiet bit would miss signaling NaNs. A design that tested only the exponent would flag zeros as flushed, or infinities as invalid. Guarded-off and idle cycles are placed right after flag-raising requests. A design that let the output register load without the guard would show the new flags there.

// File: rtl/fcx_pkg.sv
// Package: shared constants and types of the compare flag unit.
// Assumes a 32-bit flag word with fixed bit positions that a status
// consumer decodes.
package fcx_pkg;

    localparam int FLAG_W      = 32;
    localparam int FB_DIV0     = 0;
    localparam int FB_INEXACT  = 1;
    localparam int FB_UNDER    = 2;
    localparam int FB_OVER     = 3;
    localparam int FB_INVALID  = 4;
    localparam int FB_INFLUSH  = 5;
    localparam int FB_OUTFLUSH = 6;

    // Class bits of one operand that matter to a compare.
    typedef struct packed {
        logic is_nan;
        logic is_denorm;
    } opnd_class_t;

endpackage

// File: rtl/fcx_classify.sv
// Module: fcx_classify
// Classifies the magnitude of one floating-point operand (sign removed).
// Assumes the exponent field sits above the mantissa field.
module fcx_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W-1:0] mag,
    output fcx_pkg::opnd_class_t   cls
);
    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             man_nz;

    assign exp_f  = mag[EXP_W+MAN_W-1 -: EXP_W];
    assign man_f  = mag[MAN_W-1:0];
    assign man_nz = |man_f;

    // Derive the class from the exponent extremes and the mantissa.
    always_comb begin
        cls.is_nan    = (exp_f == EXP_ONES) && man_nz;
        cls.is_denorm = (exp_f == '0) && man_nz;
    end
endmodule

// File: rtl/fcx_flag_pack.sv
// Module: fcx_flag_pack
// Packs the exception flags of a >= compare into the flag word.
// Assumes the operand classes come from fcx_classify.
module fcx_flag_pack (
    input  fcx_pkg::opnd_class_t        cls_a,
    input  fcx_pkg::opnd_class_t        cls_b,
    output logic [fcx_pkg::FLAG_W-1:0]  flags
);
    import fcx_pkg::*;

    // Only invalid and input flush can arise from a compare.
    always_comb begin
        flags              = '0;
        flags[FB_DIV0]     = 1'b0;
        flags[FB_INEXACT]  = 1'b0;
        flags[FB_UNDER]    = 1'b0;
        flags[FB_OVER]     = 1'b0;
        flags[FB_OUTFLUSH] = 1'b0;
        flags[FB_INVALID]  = cls_a.is_nan | cls_b.is_nan;
        flags[FB_INFLUSH]  = cls_a.is_denorm | cls_b.is_denorm;
    end
endmodule

// File: rtl/fcx_wb_reg.sv
// Module: fcx_wb_reg
// Result register with a guarded load and a one-cycle write strobe.
// Assumes a synchronous active-low reset.
module fcx_wb_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         we
);
    // Capture the vector on an accepted request, and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q  <= '0;
            we <= 1'b0;
        end else begin
            we <= load;
            if (load) q <= d;
        end
    end
endmodule

// File: rtl/fcmp_geflags_unit.sv
// Module: fcmp_geflags_unit (top)
// Reports the IEEE exception flags of a >= compare of two operands.
// Denormal inputs count as flushed to zero. Result latency is one cycle.
// Assumes one request per cycle at most, marked by in_valid.
module fcmp_geflags_unit #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [EXP_W+MAN_W:0]        opnd_a,
    input  logic [EXP_W+MAN_W:0]        opnd_b,
    input  logic                        wr_guard,
    output logic [fcx_pkg::FLAG_W-1:0]  flags_out,
    output logic                        wr_en
);
    localparam int DW   = 1 + EXP_W + MAN_W;
    localparam int MAGW = DW - 1;
    localparam int NOP  = 2;

    logic [MAGW-1:0]          mag_arr [NOP];
    fcx_pkg::opnd_class_t     cls_arr [NOP];
    logic [fcx_pkg::FLAG_W-1:0] flags_d;
    logic                     sign_unused;
    logic                     accept;

    // Strip the signs, because a compare's flags do not depend on them.
    assign mag_arr[0]  = opnd_a[MAGW-1:0];
    assign mag_arr[1]  = opnd_b[MAGW-1:0];
    assign sign_unused = opnd_a[DW-1] ^ opnd_b[DW-1];

    for (genvar gi = 0; gi < NOP; gi++) begin : g_cls
        fcx_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .mag (mag_arr[gi]),
            .cls (cls_arr[gi])
        );
    end

    fcx_flag_pack u_pack (
        .cls_a (cls_arr[0]),
        .cls_b (cls_arr[1]),
        .flags (flags_d)
    );

    assign accept = in_valid & wr_guard;

    fcx_wb_reg #(.W(fcx_pkg::FLAG_W)) u_wb (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .d     (flags_d),
        .q     (flags_out),
        .we    (wr_en)
    );
endmodule

// File: rtl/fcmp_geflags_chk.sv
// Module: fcmp_geflags_chk
// Property checker bound to fcmp_geflags_unit.
// Assumes the top's default parameters.
module fcmp_geflags_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [EXP_W+MAN_W:0]        opnd_a,
    input logic [EXP_W+MAN_W:0]        opnd_b,
    input logic                        wr_guard,
    input logic [fcx_pkg::FLAG_W-1:0]  flags_out,
    input logic                        wr_en
);
    localparam int MAGW = EXP_W + MAN_W;
    localparam logic [fcx_pkg::FLAG_W-1:0] LIVE = 32'h0000_0030;

    logic nan_any, den_any, go, sign_unused;

    assign sign_unused = opnd_a[MAGW] ^ opnd_b[MAGW];
    assign go      = in_valid && wr_guard;
    assign nan_any = (&opnd_a[MAGW-1:MAN_W] && |opnd_a[MAN_W-1:0]) ||
                     (&opnd_b[MAGW-1:MAN_W] && |opnd_b[MAN_W-1:0]);
    assign den_any = (~|opnd_a[MAGW-1:MAN_W] && |opnd_a[MAN_W-1:0]) ||
                     (~|opnd_b[MAGW-1:MAN_W] && |opnd_b[MAN_W-1:0]);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!wr_en && flags_out == '0)); // R1
    AST_DEAD_BITS: assert property (@(posedge clk) disable iff (!rst_n) (flags_out & ~LIVE) == '0); // R2
    AST_NAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n) (go && nan_any) |=> flags_out[4]); // R3
    AST_DENORM_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) (go && den_any) |=> flags_out[5]); // R4
    AST_PLAIN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (go && !nan_any && !den_any) |=> flags_out == '0); // R5
    AST_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (go && nan_any && den_any) |=> flags_out == LIVE); // R6
    AST_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) go |=> wr_en); // R7
    AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_guard |=> (!wr_en && $stable(flags_out))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> (!wr_en && $stable(flags_out))); // R9
endmodule

bind fcmp_geflags_unit fcmp_geflags_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .wr_guard  (wr_guard),
    .flags_out (flags_out),
    .wr_en     (wr_en)
);

// File: tb/sim_fcmp_geflags_unit.sv
// Bench: directed corner cases plus seeded random operands by class.
module sim_fcmp_geflags_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        wr_guard = 1'b0;
    logic [31:0] flags_out;
    logic        wr_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] held = '0;

    always #5 clk = ~clk;

    fcmp_geflags_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .wr_guard(wr_guard), .flags_out(flags_out), .wr_en(wr_en)
    );

    function automatic logic [31:0] ref_flags(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] f = 32'h0;
        if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)) f |= 32'h10;
        if ((a[30:23] == 8'h00 && a[22:0] != 0) || (b[30:23] == 8'h00 && b[22:0] != 0)) f |= 32'h20;
        return f;
    endfunction

    function automatic logic [31:0] rand_opnd(input int kind);
        logic       s = 1'($urandom);
        logic [22:0] m = 23'($urandom);
        logic [7:0]  e;
        case (kind)
            0: begin e = 8'($urandom_range(1, 254)); return {s, e, m}; end
            1: return {s, 31'h0};
            2: return {s, 8'hFF, 23'h0};
            3: return {s, 8'hFF, 1'b1, m[21:0]};
            4: return {s, 8'hFF, 1'b0, m[21:0] | 22'h1};
            default: return {s, 8'h00, m | 23'h1};
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input bit v, input bit g, input string tag);
        logic exp_we;
        @(negedge clk);
        opnd_a = a; opnd_b = b; in_valid = v; wr_guard = g;
        @(posedge clk);
        #1;
        exp_we = v & g;
        if (exp_we) held = ref_flags(a, b);
        chk(wr_en == exp_we, {tag, " wr_en"}, {31'h0, wr_en}, {31'h0, exp_we});
        chk(flags_out == held, {tag, " flags"}, flags_out, held);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk(flags_out == 0 && wr_en == 0, "R1 reset state", flags_out, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        apply(32'h40400000, 32'h00000000, 1, 1, "R5 3.0 vs 0.0");
        apply(32'h40400000, 32'h40400000, 1, 1, "R5 equal");
        apply(32'h7FFFFFFF, 32'h3F800000, 1, 1, "R3 qnan");
        apply(32'h3F800000, 32'h40400000, 1, 0, "R8 guard low keeps 0x10");
        apply(32'h3F800000, 32'h40400000, 1, 1, "R7 guard high");
        apply(32'h40400000, 32'hFFFFFFFF, 1, 1, "R3 qnan right");
        apply(32'h7F800000, 32'hFF800000, 1, 1, "R5 +inf vs -inf");
        apply(32'h3F800000, 32'h00400000, 1, 1, "R4 denorm");
        apply(32'h7F800001, 32'h00000000, 1, 1, "R3 snan lowest bit");
        apply(32'h00000001, 32'h00000000, 0, 1, "R9 idle keeps 0x10");
        apply(32'h7F800000, 32'h7F800000, 1, 1, "R5 +inf vs itself");
        apply(32'h80000000, 32'h00000000, 1, 1, "R4 signed zeros not flushed");
        apply(32'h807FFFFF, 32'h3F800000, 1, 1, "R4 largest neg denorm");
        apply(32'hFFC00000, 32'h00000001, 1, 1, "R6 nan with denorm");
        apply(32'h7F800000, 32'h7F800000, 0, 0, "R9 idle after 0x30");
        apply(32'h7FC00000, 32'h80400000, 1, 1, "R6 nan and neg denorm");
        chk((flags_out & 32'hFFFFFFCF) == 0, "R2 dead bits", flags_out, flags_out & 32'h30);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra = rand_opnd($urandom_range(0, 5));
            logic [31:0] rb = rand_opnd($urandom_range(0, 5));
            bit rv = ($urandom_range(0, 3) != 0);
            bit rg = ($urandom_range(0, 3) != 0);
            apply(ra, rb, rv, rg, "R7 R8 R9 random");
            chk((flags_out & 32'hFFFFFFCF) == 0, "R2 random dead bits", flags_out, flags_out & 32'h30);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule